// File: doc/BRIEF.md
# Real-Time Clock Indexed Register Port

This block is the host-side register file of a real-time clock. The host reaches it through two addresses. A write to the select address latches the number of a register. An access to the data address then reads or writes that register. Behind the port sits a 128-byte store. It holds the clock fields (seconds, minutes, hours, weekday, day of month, month, year), the three alarm fields and four control registers at indices 10 to 13. The remaining indices are general-purpose storage.

Each control register has its own write rule:
- Register A keeps its top bit (the update-in-progress flag, driven by the calendar block) safe from host writes.
- Register B carries a set-mode bit. Entering set mode clears the update flag and disables the update interrupt enable (bit 4). Leaving set mode hands the clock fields to the calendar counter.
- Register C collects interrupt flags from the timer blocks and clears when read.
- Register D is read-only.

Whenever a new time must be taken over, the block raises a one-cycle load strobe. At the same time it presents the seven clock bytes on a single bus.

Top module: `rtcRegPort`

## Requirements
- R1: A write with `busSel`=0 latches `wrData[6:0]` as the register index; bit 7 is dropped. A read with `busSel`=0 returns `{1'b0, index}`.
- R2: With `busSel`=1, `rdData` shows the indexed byte without delay. The alarm fields (indices 1, 3, 5) and indices 14 to 127 return exactly the last byte written to them.
- R3: Register A (index 10) stores `wrData[6:0]` on a write, and its bit 7 keeps its value. Bit 7 is set by `calUipSet` and cleared by `calUipClr`; clear has priority.
- R4: A write to register B (index 11) with bit 7 set stores the byte with bit 4 forced to 0 and clears bit 7 of register A.
- R5: A write to register B with bit 7 at 0, while the stored bit 7 is 1, raises `timeLoad` for the single cycle after the write edge. A register B write while the stored bit 7 is 0 raises no `timeLoad`.
- R6: Writes to register C (index 12) and register D (index 13) have no effect. Register D always reads 0.
- R7: A write to a clock field (indices 0, 2, 4, 6, 7, 8, 9) stores the byte in every case. It raises `timeLoad` in the next cycle only while the stored register B bit 7 is 0.
- R8: A data read of register C returns its flags and clears them at that edge. Flags on `irqFlagSet` in the same cycle are OR-ed in and kept.
- R9: After reset the index, registers A, B and C and `timeLoad` are 0.
- R10: `timeImage` carries bytes 0, 2, 4, 6, 7, 8, 9 from least to most significant byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | 0 selects the index latch, 1 the data register |
| wrEn | input | 1 | Write strobe for the current access |
| rdEn | input | 1 | Read strobe for the current access |
| wrData | input | 8 | Write byte |
| calUipSet | input | 1 | Calendar sets the update-in-progress flag |
| calUipClr | input | 1 | Calendar clears the update-in-progress flag |
| irqFlagSet | input | 8 | Flag bits OR-ed into register C |
| rdData | output | 8 | Read byte |
| ctrlAOut | output | 8 | Current register A |
| ctrlBOut | output | 8 | Current register B |
| timeLoad | output | 1 | One-cycle strobe to load the calendar counter |
| timeImage | output | 56 | Seven clock bytes for the calendar counter |

## Verification
The hardest case to reach from the ports is a read of register C in the same cycle that the timer side posts a new flag. This is the only case where clear and set compete. The stimulus latches index 12, posts one flag, and then issues the read while holding a second flag on `irqFlagSet`. The first read must return only the older flag, and a follow-up read must show the newer one. The set-mode exit commit is reached by entering set mode, editing a clock field with no strobe seen, and then leaving set mode.

// File: rtl/rtcRegPkg.sv
package rtcRegPkg;
  localparam int IDX_W    = 7;
  localparam int BYTE_W   = 8;
  localparam int NUM_REGS = 1 << IDX_W;
  localparam int TIME_N   = 7;

  localparam logic [IDX_W-1:0] IDX_SEC  = 7'd0;
  localparam logic [IDX_W-1:0] IDX_MIN  = 7'd2;
  localparam logic [IDX_W-1:0] IDX_HOUR = 7'd4;
  localparam logic [IDX_W-1:0] IDX_WDAY = 7'd6;
  localparam logic [IDX_W-1:0] IDX_MDAY = 7'd7;
  localparam logic [IDX_W-1:0] IDX_MON  = 7'd8;
  localparam logic [IDX_W-1:0] IDX_YEAR = 7'd9;
  localparam logic [IDX_W-1:0] IDX_A    = 7'd10;
  localparam logic [IDX_W-1:0] IDX_B    = 7'd11;
  localparam logic [IDX_W-1:0] IDX_C    = 7'd12;
  localparam logic [IDX_W-1:0] IDX_D    = 7'd13;

  localparam int SET_BIT = 7;
  localparam int UIP_BIT = 7;
  localparam int UIE_BIT = 4;

  typedef struct packed {
    logic idxWe;
    logic memWe;
    logic aWe;
    logic bWe;
    logic uipClrHost;
    logic cClr;
    logic commit;
  } strobe_t;
endpackage

// File: rtl/rtcRegCtrl.sv
module rtcRegCtrl
  import rtcRegPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic             setReq,
  input  logic [IDX_W-1:0] curIdx,
  input  logic             setMode,
  output strobe_t          strb,
  output logic             timeLoad
);
  logic dataWr, dataRd, isTime, isCtrl;

  assign dataWr = wrEn && busSel;
  assign dataRd = rdEn && busSel && !wrEn;
  assign isTime = (curIdx == IDX_SEC) || (curIdx == IDX_MIN) || (curIdx == IDX_HOUR) ||
                  (curIdx == IDX_WDAY) || (curIdx == IDX_MDAY) || (curIdx == IDX_MON) ||
                  (curIdx == IDX_YEAR);
  assign isCtrl = (curIdx >= IDX_A) && (curIdx <= IDX_D);

  always_comb begin
    strb            = '0;
    strb.idxWe      = wrEn && !busSel;
    strb.memWe      = dataWr && !isCtrl;
    strb.aWe        = dataWr && (curIdx == IDX_A);
    strb.bWe        = dataWr && (curIdx == IDX_B);
    strb.uipClrHost = strb.bWe && setReq;
    strb.cClr       = dataRd && (curIdx == IDX_C);
    strb.commit     = (dataWr && isTime && !setMode) ||
                      (strb.bWe && !setReq && setMode);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timeLoad <= 1'b0;
    else       timeLoad <= strb.commit;
  end
endmodule

// File: rtl/rtcRegData.sv
module rtcRegData
  import rtcRegPkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strb,
  input  logic                     busSel,
  input  logic [BYTE_W-1:0]        wrData,
  input  logic                     calUipSet,
  input  logic                     calUipClr,
  input  logic [BYTE_W-1:0]        irqFlagSet,
  output logic [IDX_W-1:0]         idxReg,
  output logic [BYTE_W-1:0]        regA,
  output logic [BYTE_W-1:0]        regB,
  output logic [BYTE_W-1:0]        regC,
  output logic [BYTE_W-1:0]        rdData,
  output logic [TIME_N*BYTE_W-1:0] timeImage
);
  logic [BYTE_W-1:0] mem [NUM_REGS];
  logic [BYTE_W-1:0] selByte;

  always_ff @(posedge clk) begin
    if (strb.memWe) mem[idxReg] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxReg <= '0;
      regA   <= '0;
      regB   <= '0;
      regC   <= '0;
    end else begin
      if (strb.idxWe) idxReg <= wrData[IDX_W-1:0];
      if (strb.aWe) regA[UIP_BIT-1:0] <= wrData[UIP_BIT-1:0];
      if (strb.uipClrHost || calUipClr) regA[UIP_BIT] <= 1'b0;
      else if (calUipSet)               regA[UIP_BIT] <= 1'b1;
      if (strb.bWe) begin
        regB <= wrData;
        if (wrData[SET_BIT]) regB[UIE_BIT] <= 1'b0;
      end
      regC <= (strb.cClr ? '0 : regC) | irqFlagSet;
    end
  end

  always_comb begin
    case (idxReg)
      IDX_A:   selByte = regA;
      IDX_B:   selByte = regB;
      IDX_C:   selByte = regC;
      IDX_D:   selByte = '0;
      default: selByte = mem[idxReg];
    endcase
  end

  assign rdData    = busSel ? selByte : {{(BYTE_W-IDX_W){1'b0}}, idxReg};
  assign timeImage = {mem[IDX_YEAR], mem[IDX_MON], mem[IDX_MDAY], mem[IDX_WDAY],
                      mem[IDX_HOUR], mem[IDX_MIN], mem[IDX_SEC]};
endmodule

// File: rtl/rtcRegPort.sv
module rtcRegPort
  import rtcRegPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [7:0]  wrData,
  input  logic        calUipSet,
  input  logic        calUipClr,
  input  logic [7:0]  irqFlagSet,
  output logic [7:0]  rdData,
  output logic [7:0]  ctrlAOut,
  output logic [7:0]  ctrlBOut,
  output logic        timeLoad,
  output logic [55:0] timeImage
);
  strobe_t          strb;
  logic [IDX_W-1:0] idxReg;
  logic [7:0]       regC;

  rtcRegCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .wrEn(wrEn), .rdEn(rdEn),
    .setReq(wrData[SET_BIT]), .curIdx(idxReg), .setMode(ctrlBOut[SET_BIT]),
    .strb(strb), .timeLoad(timeLoad)
  );

  rtcRegData u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busSel(busSel), .wrData(wrData),
    .calUipSet(calUipSet), .calUipClr(calUipClr), .irqFlagSet(irqFlagSet),
    .idxReg(idxReg), .regA(ctrlAOut), .regB(ctrlBOut), .regC(regC),
    .rdData(rdData), .timeImage(timeImage)
  );
endmodule

// File: rtl/rtcRegChk.sv
module rtcRegChk (
  input logic       clk,
  input logic       rstN,
  input logic       busSel,
  input logic       wrEn,
  input logic       rdEn,
  input logic [7:0] wrData,
  input logic       calUipSet,
  input logic       calUipClr,
  input logic [7:0] irqFlagSet,
  input logic [6:0] idx,
  input logic [7:0] regC,
  input logic [7:0] ctrlAOut,
  input logic [7:0] ctrlBOut,
  input logic       timeLoad
);
  AST_INDEX_LOW7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !busSel) |=> (idx == $past(wrData[6:0]))); // R1

  AST_UIP_READONLY: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busSel && idx == 7'd10 && !calUipSet && !calUipClr) |=> $stable(ctrlAOut[7])); // R3

  AST_SET_DROPS_UIE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busSel && idx == 7'd11 && wrData[7]) |=> (!ctrlBOut[4] && !ctrlAOut[7])); // R4

  AST_SET_EXIT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busSel && idx == 7'd11 && !wrData[7] && ctrlBOut[7]) |=> timeLoad); // R5

  AST_C_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busSel && idx == 7'd12 && irqFlagSet == 8'h00) |=> $stable(regC)); // R6

  AST_SETMODE_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busSel && ctrlBOut[7] && idx <= 7'd9 && idx != 7'd1 && idx != 7'd3 &&
     idx != 7'd5) |=> !timeLoad); // R7

  AST_C_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && busSel && idx == 7'd12 && irqFlagSet == 8'h00) |=> (regC == 8'h00)); // R8
endmodule

bind rtcRegPort rtcRegChk u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .wrEn(wrEn), .rdEn(rdEn),
  .wrData(wrData), .calUipSet(calUipSet), .calUipClr(calUipClr),
  .irqFlagSet(irqFlagSet), .idx(u_dp.idxReg), .regC(u_dp.regC),
  .ctrlAOut(ctrlAOut), .ctrlBOut(ctrlBOut), .timeLoad(timeLoad)
);

// File: tb/rtcRegPort_tb.sv
module rtcRegPort_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic        calUipSet = 1'b0, calUipClr = 1'b0;
  logic [7:0]  irqFlagSet = '0;
  logic [7:0]  rdData, ctrlAOut, ctrlBOut;
  logic        timeLoad;
  logic [55:0] timeImage;

  int checks = 0;
  int fails = 0;
  logic [7:0] model [128];
  logic [7:0] got;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtcRegPort u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .calUipSet(calUipSet), .calUipClr(calUipClr),
    .irqFlagSet(irqFlagSet), .rdData(rdData), .ctrlAOut(ctrlAOut),
    .ctrlBOut(ctrlBOut), .timeLoad(timeLoad), .timeImage(timeImage)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(logic sel, logic [7:0] d);
    @(negedge clk);
    busSel = sel; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setIdx(logic [7:0] i);
    access(1'b0, i);
  endtask

  task automatic readByte(logic sel, output logic [7:0] v);
    @(negedge clk);
    busSel = sel; rdEn = 1'b1;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic pulseFlags(logic [7:0] f);
    @(negedge clk);
    irqFlagSet = f;
    @(negedge clk);
    irqFlagSet = '0;
  endtask

  function automatic logic [7:0] plainIdx(int unsigned r);
    return (r < 3) ? 8'(1 + 2 * r) : 8'(14 + (r - 3));
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0017));
    repeat (3) @(negedge clk);
    #1;
    // R9 reset state
    check("R9 index", {56'd0, rdData}, 64'h00);
    check("R9 timeLoad", {63'd0, timeLoad}, 64'd0);
    check("R9 regA", {56'd0, ctrlAOut}, 64'h00);
    check("R9 regB", {56'd0, ctrlBOut}, 64'h00);
    rstN = 1'b1;
    setIdx(8'd12);
    readByte(1'b1, got);
    check("R9 regC", {56'd0, got}, 64'h00);

    // R1 index latch keeps low 7 bits
    setIdx(8'hFF);
    readByte(1'b0, got);
    check("R1 index mask", {56'd0, got}, 64'h7F);
    setIdx(8'h8E);
    readByte(1'b0, got);
    check("R1 index 0x8E", {56'd0, got}, 64'h0E);
    access(1'b1, 8'h5A);
    model[14] = 8'h5A;
    readByte(1'b1, got);
    check("R2 storage 14", {56'd0, got}, 64'h5A);

    // R7 / R10 time writes with set mode off
    begin
      logic [7:0] tIdx [7] = '{8'd0, 8'd2, 8'd4, 8'd6, 8'd7, 8'd8, 8'd9};
      logic [7:0] tVal [7] = '{8'h45, 8'h59, 8'h23, 8'h03, 8'h31, 8'h12, 8'h99};
      logic [55:0] expImg;
      expImg = '0;
      for (int k = 0; k < 7; k++) begin
        setIdx(tIdx[k]);
        access(1'b1, tVal[k]);
        check("R7 load on time write", {63'd0, timeLoad}, 64'd1);
        expImg[k*8 +: 8] = tVal[k];
      end
      check("R10 time image", {8'd0, timeImage}, {8'd0, expImg});
    end

    // R3 update flag from calendar, host bits only
    @(negedge clk); calUipSet = 1'b1;
    @(negedge clk); calUipSet = 1'b0;
    check("R3 uip set", {63'd0, ctrlAOut[7]}, 64'd1);
    setIdx(8'd10);
    access(1'b1, 8'h26);
    check("R3 A write keeps uip", {56'd0, ctrlAOut}, 64'hA6);
    access(1'b1, 8'h7F);
    check("R3 A low bits", {56'd0, ctrlAOut}, 64'hFF);
    @(negedge clk); calUipClr = 1'b1;
    @(negedge clk); calUipClr = 1'b0;
    check("R3 uip clear", {56'd0, ctrlAOut}, 64'h7F);
    access(1'b1, 8'h80);
    check("R3 host cannot set uip", {56'd0, ctrlAOut}, 64'h00);

    // R4 entering set mode
    @(negedge clk); calUipSet = 1'b1;
    @(negedge clk); calUipSet = 1'b0;
    setIdx(8'd11);
    access(1'b1, 8'hFF);
    check("R4 B stored without UIE", {56'd0, ctrlBOut}, 64'hEF);
    check("R4 uip cleared", {63'd0, ctrlAOut[7]}, 64'd0);
    check("R5 no load entering set", {63'd0, timeLoad}, 64'd0);

    // R7 set mode suppresses commit
    setIdx(8'd2);
    access(1'b1, 8'h33);
    check("R7 no load in set mode", {63'd0, timeLoad}, 64'd0);
    readByte(1'b1, got);
    check("R7 stored in set mode", {56'd0, got}, 64'h33);

    // R5 leaving set mode commits
    setIdx(8'd11);
    access(1'b1, 8'h12);
    check("R5 load on set exit", {63'd0, timeLoad}, 64'd1);
    check("R5 B value", {56'd0, ctrlBOut}, 64'h12);
    check("R10 minute byte", {56'd0, timeImage[15:8]}, 64'h33);
    @(negedge clk);
    check("R5 single cycle", {63'd0, timeLoad}, 64'd0);
    access(1'b1, 8'h02);
    check("R5 no load without set", {63'd0, timeLoad}, 64'd0);

    // R6 / R8 register C
    setIdx(8'd12);
    access(1'b1, 8'hFF);
    readByte(1'b1, got);
    check("R6 C write ignored", {56'd0, got}, 64'h00);
    pulseFlags(8'hC0);
    readByte(1'b1, got);
    check("R8 C flags read", {56'd0, got}, 64'hC0);
    readByte(1'b1, got);
    check("R8 C cleared", {56'd0, got}, 64'h00);
    pulseFlags(8'h80);
    @(negedge clk);
    busSel = 1'b1; rdEn = 1'b1; irqFlagSet = 8'h40;
    #1 got = rdData;
    @(negedge clk);
    rdEn = 1'b0; irqFlagSet = '0;
    check("R8 read before new flag", {56'd0, got}, 64'h80);
    readByte(1'b1, got);
    check("R8 same-cycle flag kept", {56'd0, got}, 64'h40);
    setIdx(8'd13);
    access(1'b1, 8'h55);
    readByte(1'b1, got);
    check("R6 D reads zero", {56'd0, got}, 64'h00);

    // R2 random plain storage traffic
    for (int n = 0; n < 300; n++) begin
      logic [7:0] ix, v;
      ix = plainIdx($urandom % 117);
      v  = 8'($urandom);
      setIdx(ix);
      access(1'b1, v);
      model[ix] = v;
      check("R7 no load on plain write", {63'd0, timeLoad}, 64'd0);
    end
    for (int n = 0; n < 117; n++) begin
      logic [7:0] ix;
      ix = plainIdx(n);
      if (model[ix] !== 8'hxx) begin
        setIdx(ix);
        readByte(1'b1, got);
        check("R2 readback", {56'd0, got}, {56'd0, model[ix]});
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule